// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block sits at the front of a five-stage in-order pipeline. It owns the fetch program counter and the IF/ID pipeline register. It settles conditional branches while they are still in decode, using its own operand comparator and its own target adder. From the outcome it chooses the next fetch address and decides whether the IF/ID register is squashed or held.

The surrounding decode logic supplies the branch kind, the two source operands read from the register file and the sign-extended immediate. The instruction store returns the word at the current fetch address. A run-time mode input picks one of three ways to handle the instruction fetched behind a branch: always stall one cycle, keep fetching sequentially and squash on a taken branch, or treat that instruction as a delay slot that always runs. An external stall input freezes the front end. While it is high, a branch waiting in decode is left unresolved.

Top module: `id_branch_resolver`

## Requirements
- R1: A synchronous active-high reset sets the fetch PC to 0, clears the IF/ID valid bit and clears the IF/ID instruction to all zeros.
- R2: With no branch resolving and no external stall, each rising edge advances the fetch PC by 4. The IF/ID register takes the fetched word and its address, with valid set.
- R3: Branch kind 2'b01 is taken when the two operands are equal, and kind 2'b10 is taken when the first operand is non-zero. Kinds 2'b00 and 2'b11 are not branches. The taken output is high only in a cycle where a taken branch resolves.
- R4: The taken target is the decode PC plus 4 plus the immediate shifted left by two, with the immediate read as two's complement.
- R5: In mode 2'b00 (stall), every resolving branch squashes IF/ID. A taken branch loads the target into the fetch PC. A not-taken branch holds the fetch PC for one edge and drives the fetch-stall output high, so the same address is fetched again.
- R6: In mode 2'b01 (predict not taken), and also for the unused code 2'b11, a not-taken branch costs nothing: there is no squash and the fetch PC advances by 4. A taken branch squashes IF/ID and loads the target.
- R7: In mode 2'b10 (delay slot), no branch ever squashes. The instruction fetched behind the branch enters IF/ID with valid set, and a taken branch loads the target.
- R8: A squash leaves IF/ID holding the all-zero instruction with valid cleared.
- R9: While the external stall is high, the fetch PC and IF/ID hold, the fetch-stall output is high, and there is neither a squash nor a taken indication. A branch held in decode resolves once the stall drops.
- R10: The branch kind and operands have no effect while the IF/ID valid bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Branch policy: 00 stall, 01 predict not taken, 10 delay slot, 11 as 01 |
| stallIn | input | 1 | Front-end stall requested from elsewhere |
| brKind | input | 2 | Branch kind decoded from the IF/ID instruction |
| opA | input | XLEN | First register operand |
| opB | input | XLEN | Second register operand |
| immSext | input | XLEN | Sign-extended word offset |
| fetchInstr | input | IW | Word read at fetchPc |
| fetchPc | output | XLEN | Current fetch address |
| idInstr | output | IW | IF/ID instruction |
| idPc | output | XLEN | IF/ID instruction address |
| idValid | output | 1 | IF/ID holds a live instruction |
| ifStall | output | 1 | Fetch PC is held at this edge |
| ifidFlush | output | 1 | IF/ID is squashed at this edge |
| brTaken | output | 1 | A taken branch resolves this cycle |

## Verification
A wrong condition or policy decision shows up in the same cycle on the squash, stall and taken outputs. At the next edge it also appears as a wrong fetch address, or as a wrong IF/ID word or valid bit. A bad target sum shows in fetchPc one edge after the taken branch. An IF/ID register that lost its hold during a stall, or kept a squashed word, differs from the expected contents within one cycle. The bench compares every one of these on every cycle, so a fault is reported in the cycle it first becomes visible.

// File: rtl/brres_pkg.sv
`timescale 1ns/1ps
package brres_pkg;

  typedef enum logic [1:0] {
    POL_STALL = 2'b00,
    POL_PNT   = 2'b01,
    POL_DELAY = 2'b10,
    POL_PNT2  = 2'b11
  } policy_e;

  typedef enum logic [1:0] {
    BK_NONE  = 2'b00,
    BK_EQ    = 2'b01,
    BK_NEZ   = 2'b10,
    BK_RSVD  = 2'b11
  } brkind_e;

  typedef struct packed {
    logic redirect;
    logic hold;
    logic flush;
  } strobes_t;

endpackage

// File: rtl/brres_control.sv
`timescale 1ns/1ps
module brres_control
  import brres_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       stallIn,
  input  logic       idValid,
  input  logic [1:0] brKind,
  input  logic       condTrue,
  output strobes_t   strobes,
  output logic       ifStall,
  output logic       ifidFlush,
  output logic       brTaken
);

  policy_e policy;
  brkind_e kind;
  logic    isBranch;
  logic    resolving;
  logic    takenNow;

  assign policy = policy_e'(mode);
  assign kind   = brkind_e'(brKind);

  always_comb begin
    isBranch  = (kind == BK_EQ) || (kind == BK_NEZ);
    resolving = idValid && isBranch && !stallIn;
    takenNow  = resolving && condTrue;

    strobes.redirect = takenNow;
    strobes.hold     = stallIn;
    strobes.flush    = 1'b0;

    if (resolving) begin
      unique case (policy)
        POL_STALL: begin
          strobes.flush = 1'b1;
          strobes.hold  = !condTrue;
        end
        POL_PNT, POL_PNT2: strobes.flush = condTrue;
        POL_DELAY:         strobes.flush = 1'b0;
        default:           strobes.flush = 1'b0;
      endcase
    end
  end

  assign ifStall   = strobes.hold;
  assign ifidFlush = strobes.flush;
  assign brTaken   = takenNow;

  AST_DELAY_NO_SQUASH: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> !ifidFlush);  // R7

  AST_STALL_NO_RESOLVE: assert property (@(posedge clk) disable iff (rst)
    stallIn |-> (!ifidFlush && !brTaken));  // R9

  AST_IDLE_NO_ACTION: assert property (@(posedge clk) disable iff (rst)
    !idValid |-> (!ifidFlush && !brTaken));  // R10

endmodule

// File: rtl/brres_datapath.sv
`timescale 1ns/1ps
module brres_datapath
  import brres_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  strobes_t        strobes,
  input  logic [1:0]      brKind,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [XLEN-1:0] immSext,
  input  logic [IW-1:0]   fetchInstr,
  output logic            condTrue,
  output logic [XLEN-1:0] fetchPc,
  output logic [IW-1:0]   idInstr,
  output logic [XLEN-1:0] idPc,
  output logic            idValid
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);
  localparam int              SHAMT = 2;

  logic [XLEN-1:0] pcQ;
  logic [XLEN-1:0] idPcQ;
  logic [IW-1:0]   idInstrQ;
  logic            idValidQ;
  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] targetPc;
  logic [XLEN-1:0] pcD;

  always_comb begin
    unique case (brkind_e'(brKind))
      BK_EQ:   condTrue = (opA == opB);
      BK_NEZ:  condTrue = (opA != '0);
      default: condTrue = 1'b0;
    endcase
  end

  assign seqPc    = pcQ + STEP;
  assign targetPc = idPcQ + STEP + (immSext << SHAMT);

  always_comb begin
    if (strobes.redirect)  pcD = targetPc;
    else if (strobes.hold) pcD = pcQ;
    else                   pcD = seqPc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ      <= '0;
      idPcQ    <= '0;
      idInstrQ <= '0;
      idValidQ <= 1'b0;
    end else begin
      pcQ <= pcD;
      if (strobes.flush) begin
        idInstrQ <= '0;
        idValidQ <= 1'b0;
        idPcQ    <= pcQ;
      end else if (!strobes.hold) begin
        idInstrQ <= fetchInstr;
        idValidQ <= 1'b1;
        idPcQ    <= pcQ;
      end
    end
  end

  assign fetchPc = pcQ;
  assign idInstr = idInstrQ;
  assign idPc    = idPcQ;
  assign idValid = idValidQ;

  AST_SQUASH_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    strobes.flush |=> (!idValidQ && idInstrQ == '0));  // R8

  AST_HOLD_FREEZES_PC: assert property (@(posedge clk) disable iff (rst)
    (strobes.hold && !strobes.redirect) |=> $stable(pcQ));  // R5

  AST_STALL_FREEZES_IFID: assert property (@(posedge clk) disable iff (rst)
    (strobes.hold && !strobes.flush) |=> ($stable(idInstrQ) && $stable(idValidQ)));  // R9

  AST_PLAIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!strobes.hold && !strobes.redirect && !strobes.flush) |=>
      (idValidQ && idPcQ == $past(pcQ)));  // R2

endmodule

// File: rtl/id_branch_resolver.sv
`timescale 1ns/1ps
module id_branch_resolver
  import brres_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode,
  input  logic            stallIn,
  input  logic [1:0]      brKind,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [XLEN-1:0] immSext,
  input  logic [IW-1:0]   fetchInstr,
  output logic [XLEN-1:0] fetchPc,
  output logic [IW-1:0]   idInstr,
  output logic [XLEN-1:0] idPc,
  output logic            idValid,
  output logic            ifStall,
  output logic            ifidFlush,
  output logic            brTaken
);

  strobes_t strobes;
  logic     condTrue;

  brres_control u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .stallIn   (stallIn),
    .idValid   (idValid),
    .brKind    (brKind),
    .condTrue  (condTrue),
    .strobes   (strobes),
    .ifStall   (ifStall),
    .ifidFlush (ifidFlush),
    .brTaken   (brTaken)
  );

  brres_datapath #(.XLEN(XLEN), .IW(IW)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .brKind     (brKind),
    .opA        (opA),
    .opB        (opB),
    .immSext    (immSext),
    .fetchInstr (fetchInstr),
    .condTrue   (condTrue),
    .fetchPc    (fetchPc),
    .idInstr    (idInstr),
    .idPc       (idPc),
    .idValid    (idValid)
  );

  AST_RESET_PC_ZERO: assert property (@(posedge clk)
    $fell(rst) |-> (fetchPc == '0 && !idValid));  // R1

endmodule

// File: tb/id_branch_resolver_test.sv
`timescale 1ns/1ps
module id_branch_resolver_test;

  localparam int XLEN = 32;
  localparam int IW   = 32;

  typedef struct {
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] idPc;
    logic [IW-1:0]   instr;
    logic            valid;
    string           req;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst;
  logic [1:0]      mode;
  logic            stallIn;
  logic [1:0]      brKind;
  logic [XLEN-1:0] opA, opB, immSext;
  logic [IW-1:0]   fetchInstr;
  logic [XLEN-1:0] fetchPc, idPc;
  logic [IW-1:0]   idInstr;
  logic            idValid, ifStall, ifidFlush, brTaken;

  int checks = 0;
  int errors = 0;
  exp_t expQ[$];

  logic [XLEN-1:0] mPc, mIdPc;
  logic [IW-1:0]   mInstr;
  logic            mValid;

  always #2.5 clk = ~clk;

  function automatic logic [IW-1:0] imem(input logic [XLEN-1:0] a);
    return {a[15:0], 16'h5A5A};
  endfunction

  assign fetchInstr = imem(fetchPc);

  id_branch_resolver #(.XLEN(XLEN), .IW(IW)) uut (
    .clk(clk), .rst(rst), .mode(mode), .stallIn(stallIn), .brKind(brKind),
    .opA(opA), .opB(opB), .immSext(immSext), .fetchInstr(fetchInstr),
    .fetchPc(fetchPc), .idInstr(idInstr), .idPc(idPc), .idValid(idValid),
    .ifStall(ifStall), .ifidFlush(ifidFlush), .brTaken(brTaken)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: compares registered state one edge after each driven cycle
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.req, "fetchPc", 64'(fetchPc), 64'(e.pc));
      check(e.req, "idValid", 64'(idValid), 64'(e.valid));
      check(e.req, "idInstr", 64'(idInstr), 64'(e.instr));
      if (e.valid) check(e.req, "idPc", 64'(idPc), 64'(e.idPc));
    end
  end

  // driver: applies one cycle of stimulus, checks same-cycle outputs, queues next state
  task automatic cyc(input logic [1:0] md, input logic st, input logic [1:0] bk,
                     input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                     input logic [XLEN-1:0] imm, input string req);
    logic isBr, cond, res, taken, hold, flush;
    logic [XLEN-1:0] tgt;
    exp_t e;
    mode = md; stallIn = st; brKind = bk; opA = a; opB = b; immSext = imm;
    isBr  = (bk == 2'b01) || (bk == 2'b10);
    cond  = (bk == 2'b01) ? (a == b) : (bk == 2'b10) ? (a != 0) : 1'b0;
    res   = mValid && isBr && !st;
    taken = res && cond;
    tgt   = mIdPc + 4 + (imm << 2);
    hold  = st || (res && md == 2'b00 && !cond);
    flush = res && ((md == 2'b00) || ((md == 2'b01 || md == 2'b11) && cond));
    #1;
    check(req, "ifidFlush", 64'(ifidFlush), 64'(flush));
    check(req, "ifStall", 64'(ifStall), 64'(hold && !taken));
    check(req, "brTaken", 64'(brTaken), 64'(taken));
    if (flush) begin
      mInstr = '0; mValid = 1'b0; mIdPc = mPc;
    end else if (!hold) begin
      mInstr = imem(mPc); mValid = 1'b1; mIdPc = mPc;
    end
    mPc = taken ? tgt : (hold ? mPc : mPc + 4);
    e.pc = mPc; e.idPc = mIdPc; e.instr = mInstr; e.valid = mValid; e.req = req;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; mode = 2'b01; stallIn = 1'b0; brKind = 2'b00;
    opA = '0; opB = '0; immSext = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "fetchPc", 64'(fetchPc), 64'h0);
    check("R1", "idValid", 64'(idValid), 64'h0);
    check("R1", "idInstr", 64'(idInstr), 64'h0);
    mPc = '0; mIdPc = '0; mInstr = '0; mValid = 1'b0;

    // sequential fetch
    cyc(2'b01, 0, 2'b00, 0, 0, 0, "R2");
    cyc(2'b01, 0, 2'b00, 0, 0, 0, "R2");
    cyc(2'b01, 0, 2'b00, 0, 0, 0, "R2");
    // predict not taken: equal operands taken
    cyc(2'b01, 0, 2'b01, 32'h11, 32'h11, 32'd8, "R6");
    // IF/ID invalid after squash: branch fields ignored
    cyc(2'b01, 0, 2'b01, 32'h7, 32'h7, 32'd100, "R10");
    cyc(2'b01, 0, 2'b00, 0, 0, 0, "R2");
    cyc(2'b01, 0, 2'b01, 32'h7, 32'h8, 32'd4, "R3");
    cyc(2'b01, 0, 2'b10, 32'h0, 32'h9, 32'd4, "R3");
    // negative offset, not-zero test taken
    cyc(2'b01, 0, 2'b10, 32'h5, 32'h0, 32'hFFFF_FFFD, "R4");
    cyc(2'b01, 0, 2'b00, 0, 0, 0, "R2");
    // reserved kind is not a branch
    cyc(2'b01, 0, 2'b11, 32'h3, 32'h3, 32'd16, "R3");
    // unused mode code behaves as predict not taken
    cyc(2'b11, 0, 2'b01, 32'h3, 32'h3, 32'd5, "R6");
    cyc(2'b00, 0, 2'b00, 0, 0, 0, "R2");
    // stall mode: not taken holds and squashes, taken squashes and redirects
    cyc(2'b00, 0, 2'b01, 32'h1, 32'h2, 32'd3, "R5");
    cyc(2'b00, 0, 2'b00, 0, 0, 0, "R5");
    cyc(2'b00, 0, 2'b01, 32'h4, 32'h4, 32'd6, "R5");
    cyc(2'b00, 0, 2'b00, 0, 0, 0, "R8");
    cyc(2'b10, 0, 2'b00, 0, 0, 0, "R2");
    // delay slot: never squashed
    cyc(2'b10, 0, 2'b10, 32'hA, 32'h0, 32'd10, "R7");
    cyc(2'b10, 0, 2'b00, 0, 0, 0, "R7");
    cyc(2'b10, 0, 2'b10, 32'h0, 32'h0, 32'd10, "R7");
    cyc(2'b01, 0, 2'b00, 0, 0, 0, "R2");
    // external stall defers a taken branch
    cyc(2'b01, 1, 2'b01, 32'h2, 32'h2, 32'd7, "R9");
    cyc(2'b01, 1, 2'b01, 32'h2, 32'h2, 32'd7, "R9");
    cyc(2'b01, 0, 2'b01, 32'h2, 32'h2, 32'd7, "R9");
    cyc(2'b01, 0, 2'b00, 0, 0, 0, "R8");
    cyc(2'b01, 0, 2'b00, 0, 0, 0, "R2");
    @(posedge clk); #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule